// File: doc/BRIEF.md
# Split-Read Coherent Cycle Counter

This block keeps a free-running 64-bit count of system clocks and lets a 32-bit processor read it through one 32-bit data port. Each transfer returns one half of the count. Software reads the upper half first and the lower half two clocks later. Together the two values form one consistent 64-bit snapshot: the value the count held at the moment of the lower-half read.

To achieve this, the upper half handed out by a high read is already compensated for the two-clock gap. It equals the upper word of the count two clocks ahead, so any carry the lower word produces between the two reads is already included. The lower-half read never uses a stored copy; it always returns the live lower word. A high read also raises an interrupt-inhibit output for two clocks. The interrupt controller uses it so that nothing can be slipped between the two halves. The block is built around a lower-word counter plus an upper word that carries early: it steps when the lower word passes the value that lies the read gap below its wrap point.

Top module: `tsSplitTimer`

## Requirements
- R1: A synchronous active-high `rst` loads the count with parameter `RESET_VALUE` (default zero) and clears `rdData` and `irqHold` to 0. The first running edge after reset sees the count equal to `RESET_VALUE`.
- R2: The count advances by exactly one on every non-reset clock edge and wraps modulo 2^64. Two low reads N edges apart return values that differ by N modulo 2^32.
- R3: A low read (`rdEn`=1, `rdHigh`=0 at an edge) puts bits [31:0] of the count at that edge on `rdData`, valid from the following cycle.
- R4: A high read (`rdEn`=1, `rdHigh`=1 at an edge) puts bits [63:32] of (count at that edge + 2) on `rdData`, valid from the following cycle.
- R5: A high read at edge t followed by a low read at edge t+2 yields {high, low} equal to the full 64-bit count at edge t+2. This also holds when the lower word rolls over anywhere inside or around the pair, including a wrap of all 64 bits.
- R6: After a high read, `irqHold` is 1 for exactly the two cycles that follow the read edge, then returns to 0 unless another high read occurs.
- R7: A high read issued while `irqHold` is already 1 restarts the window, so `irqHold` stays 1 for two cycles counted from the newest high read.
- R8: When `rdEn` is 0 at an edge, `rdData` keeps its previous value.
- R9: A low read returns the live lower word regardless of any earlier high read. No lower word is captured by a high read.
- R10: Low reads never raise `irqHold`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdEn | input | 1 | Read strobe, sampled on the rising edge |
| rdHigh | input | 1 | With `rdEn`: 1 selects the compensated upper half, 0 the live lower half |
| rdData | output | 32 | Registered read result, valid the cycle after the strobe |
| irqHold | output | 1 | Interrupt inhibit, high for two cycles after a high read |

## Verification
The delicate coincidence is the early carry into the upper word landing in the same cycle as a high read, or between a high read and its low read. The bench provokes it by restarting the counter just below a lower-word rollover. It then places the low read of a pair at every offset from four clocks before to four clocks after the wrap, with the starting value chosen so that the wrap also carries out of all 64 bits. Each pair is judged against a behavioural 64-bit model that is advanced on every clock. A second coincidence is a high read arriving while the inhibit window is still open; it is checked by issuing back-to-back high reads and watching the window stretch.

// File: rtl/tsPkg.sv
package tsPkg;

  // Strobes sent from the read control to the count datapath each cycle.
  typedef struct packed {
    logic grabHigh;  // load rdData with the compensated upper word
    logic grabLow;   // load rdData with the live lower word
    logic bumpHigh;  // early carry into the upper word
  } tsStrobe_t;

endpackage

// File: rtl/tsCountPath.sv
module tsCountPath
  import tsPkg::*;
#(
  parameter int                    HALF_W      = 32,
  parameter int                    READ_GAP    = 2,
  parameter logic [2*HALF_W-1:0]   RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  tsStrobe_t         strobe,
  output logic              nearWrap,
  output logic [HALF_W-1:0] rdData
);

  localparam int CNT_W = 2 * HALF_W;
  // Upper word is kept READ_GAP counts ahead of the real count.
  localparam logic [CNT_W-1:0]  AHEAD_INIT = RESET_VALUE + CNT_W'(READ_GAP);
  // Lower-word value at which the look-ahead upper word must step.
  localparam logic [HALF_W-1:0] WRAP_MARK  = {HALF_W{1'b1}} - HALF_W'(READ_GAP);

  logic [HALF_W-1:0] lowCnt;
  logic [HALF_W-1:0] hiAhead;

  always_comb nearWrap = (lowCnt == WRAP_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt  <= RESET_VALUE[HALF_W-1:0];
      hiAhead <= AHEAD_INIT[CNT_W-1:HALF_W];
    end else begin
      lowCnt <= lowCnt + HALF_W'(1);
      if (strobe.bumpHigh) hiAhead <= hiAhead + HALF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.grabHigh) begin
      rdData <= hiAhead;
    end else if (strobe.grabLow) begin
      rdData <= lowCnt;
    end
  end

endmodule

// File: rtl/tsReadCtrl.sv
module tsReadCtrl
  import tsPkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rdEn,
  input  logic      rdHigh,
  input  logic      nearWrap,
  output tsStrobe_t strobe,
  output logic      irqHold
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [HOLD_W-1:0] holdLeft;
  logic              highReq;

  always_comb begin
    highReq         = rdEn & rdHigh;
    strobe.grabHigh = highReq;
    strobe.grabLow  = rdEn & ~rdHigh;
    strobe.bumpHigh = nearWrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdLeft <= '0;
    end else if (highReq) begin
      holdLeft <= HOLD_W'(HOLD_CYC);
    end else if (holdLeft != '0) begin
      holdLeft <= holdLeft - HOLD_W'(1);
    end
  end

  always_comb irqHold = (holdLeft != '0);

endmodule

// File: rtl/tsSplitTimer.sv
module tsSplitTimer
  import tsPkg::*;
#(
  parameter int                  HALF_W      = 32,
  parameter int                  READ_GAP    = 2,
  parameter logic [2*HALF_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic              rdHigh,
  output logic [HALF_W-1:0] rdData,
  output logic              irqHold
);

  tsStrobe_t strobe;
  logic      nearWrap;

  tsReadCtrl #(
    .HOLD_CYC (READ_GAP)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rdEn     (rdEn),
    .rdHigh   (rdHigh),
    .nearWrap (nearWrap),
    .strobe   (strobe),
    .irqHold  (irqHold)
  );

  tsCountPath #(
    .HALF_W      (HALF_W),
    .READ_GAP    (READ_GAP),
    .RESET_VALUE (RESET_VALUE)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .nearWrap (nearWrap),
    .rdData   (rdData)
  );

endmodule

// File: rtl/tsSplitTimerChk.sv
module tsSplitTimerChk #(
  parameter int                  HALF_W      = 32,
  parameter int                  READ_GAP    = 2,
  parameter logic [2*HALF_W-1:0] RESET_VALUE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic              rdHigh,
  input logic [HALF_W-1:0] rdData,
  input logic              irqHold
);

  localparam int CNT_W = 2 * HALF_W;

  // Independent flat 64-bit shadow of the count.
  logic [CNT_W-1:0] shadow;
  always_ff @(posedge clk) begin
    if (rst) shadow <= RESET_VALUE;
    else     shadow <= shadow + CNT_W'(1);
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rdEn && !rdHigh && $past(rdEn && !rdHigh))
      |=> (rdData == $past(rdData) + HALF_W'(1)));

  // R3
  low_live_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !rdHigh) |=> (rdData == $past(shadow[HALF_W-1:0])));

  // R4
  high_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdHigh)
      |=> (rdData == HALF_W'(($past(shadow) + CNT_W'(READ_GAP)) >> HALF_W)));

  // R5
  pair_coherent_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !rdHigh && !$past(rdEn) && $past(rdEn && rdHigh, 2)
       && !$past(rst) && !$past(rst, 2))
      |=> ({$past(rdData, 2), rdData} == $past(shadow)));

  // R6
  hold_open_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdHigh) |=> irqHold ##1 irqHold);

  // R6
  hold_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rdEn && rdHigh) && !$past(rdEn && rdHigh)) |=> !irqHold);

  // R7
  hold_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdHigh && irqHold) |=> irqHold ##1 irqHold);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdEn) |=> $stable(rdData));

endmodule

bind tsSplitTimer tsSplitTimerChk #(
  .HALF_W      (HALF_W),
  .READ_GAP    (READ_GAP),
  .RESET_VALUE (RESET_VALUE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rdEn    (rdEn),
  .rdHigh  (rdHigh),
  .rdData  (rdData),
  .irqHold (irqHold)
);

// File: tb/tsSplitTimer_bench.sv
`timescale 1ns/1ps
module tsSplitTimer_bench;

  localparam logic [63:0] START = 64'hFFFF_FFFF_FFFF_FF80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdEn = 1'b0;
  logic        rdHigh = 1'b0;
  logic [31:0] rdData;
  logic        irqHold;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit checking = 1'b0;

  always #5 clk = ~clk;

  tsSplitTimer #(
    .HALF_W      (32),
    .READ_GAP    (2),
    .RESET_VALUE (START)
  ) u_tsSplitTimer (
    .clk     (clk),
    .rst     (rst),
    .rdEn    (rdEn),
    .rdHigh  (rdHigh),
    .rdData  (rdData),
    .irqHold (irqHold)
  );

  // Behavioural reference: a plain 64-bit integer count and a hold countdown.
  logic [63:0] refCnt = '0;
  logic [63:0] lowSnap = '0;
  logic [31:0] expData = '0;
  int          holdLeft = 0;
  string       lastTag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      refCnt   = START;
      expData  = '0;
      holdLeft = 0;
      lastTag  = "R1";
    end else begin
      if (rdEn && rdHigh) begin
        expData  = 32'((refCnt + 64'd2) >> 32);
        holdLeft = 2;
        lastTag  = "R4";
      end else begin
        if (rdEn) begin
          expData = refCnt[31:0];
          lowSnap = refCnt;
          lastTag = "R3";
        end else begin
          lastTag = "R8";
        end
        if (holdLeft > 0) holdLeft = holdLeft - 1;
      end
      refCnt = refCnt + 64'd1;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (checking) begin
      check(rdData === expData, {lastTag, " rdData"}, 64'(rdData), 64'(expData));
      check(irqHold === (holdLeft > 0), "R6/R7/R10 irqHold",
            64'(irqHold), 64'(holdLeft > 0));
    end
  end

  task automatic doReset();
    rst  = 1'b1;
    rdEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic readPair(output logic [63:0] got);
    logic [31:0] hiW;
    rdEn = 1'b1; rdHigh = 1'b1;
    @(negedge clk);
    hiW  = rdData;
    rdEn = 1'b0;
    @(negedge clk);
    rdEn = 1'b1; rdHigh = 1'b0;
    @(negedge clk);
    got  = {hiW, rdData};
    rdEn = 1'b0;
  endtask

  initial begin
    logic [63:0] got;
    logic [31:0] first;
    @(negedge clk);
    doReset();
    checking = 1'b1;
    // R1: state right after reset
    check(rdData === 32'h0 && irqHold === 1'b0, "R1 reset outputs",
          {31'h0, irqHold, rdData}, 64'h0);
    rdEn = 1'b1; rdHigh = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData === START[31:0], "R1 first count", 64'(rdData), 64'(START[31:0]));

    // R2: low reads four edges apart differ by four
    first = rdData;
    repeat (3) @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData === first + 32'd4, "R2 step", 64'(rdData), 64'(first + 32'd4));

    // R5: pairs with the low read at rollover offsets -4..+4 (also a 64-bit wrap)
    for (int k = -4; k <= 4; k++) begin
      doReset();
      while (refCnt[31:0] != 32'(k - 2)) @(negedge clk);
      readPair(got);
      check(got === lowSnap, "R5 pair vs model", got, lowSnap);
      check(got[63:32] === ((k < 0) ? 32'hFFFF_FFFF : 32'h0), "R5 upper across wrap",
            64'(got[63:32]), (k < 0) ? 64'hFFFF_FFFF : 64'h0);
      check(got[31:0] === 32'(k), "R5 lower offset", 64'(got[31:0]), 64'(32'(k)));
    end

    // R9: high read, long gap, then low read returns the live word
    rdEn = 1'b1; rdHigh = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    repeat (4) @(negedge clk);
    rdEn = 1'b1; rdHigh = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData === lowSnap[31:0], "R9 live low", 64'(rdData), 64'(lowSnap[31:0]));

    // R6/R7: two high reads back to back stretch the window to three cycles
    rdEn = 1'b1; rdHigh = 1'b1;
    @(negedge clk);
    check(irqHold === 1'b1, "R6 hold first", 64'(irqHold), 64'h1);
    @(negedge clk);
    rdEn = 1'b0;
    check(irqHold === 1'b1, "R7 hold restart", 64'(irqHold), 64'h1);
    @(negedge clk);
    check(irqHold === 1'b1, "R7 hold extended", 64'(irqHold), 64'h1);
    @(negedge clk);
    check(irqHold === 1'b0, "R6 hold closed", 64'(irqHold), 64'h0);

    // R10: consecutive low reads leave the inhibit low
    rdEn = 1'b1; rdHigh = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(irqHold === 1'b0, "R10 low read no hold", 64'(irqHold), 64'h0);
    end
    rdEn = 1'b0;

    // R8: idle cycles keep the last read value
    @(negedge clk);
    first = rdData;
    repeat (5) @(negedge clk);
    check(rdData === first, "R8 idle hold", 64'(rdData), 64'(first));

    checking = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule